// File: doc/BRIEF.md
# Dual-Mode Decimal/Binary Digit Adder

This block adds two 4-bit digits and a carry-in in one combinational pass. A single lookahead binary stage forms a 5-bit raw sum. A mode pin decides what reaches the outputs. In binary mode the raw sum goes out untouched. In decimal mode a correction stage detects a result above nine, folds it back into a valid BCD digit and raises the decimal carry.

Digits are chained by wiring one instance's carry-out to the next instance's carry-in, which builds multi-digit decimal or binary adders. Operand digits above nine are not part of the decimal domain, and their decimal-mode result is left unspecified.

Top module: `bcd_digit_adder`

## Requirements
- R1: The lookahead stage forms the raw 5-bit value opnd_a + opnd_b + carry_in for all 512 input combinations, with every carry computed from the propagate (a|b) and generate (a&b) terms and the carry-in only.
- R2: With dec_mode = 0 (binary), {carry_out, digit_sum} equals the raw 5-bit sum for every input combination.
- R3: With dec_mode = 1 (decimal) and both digits in 0..9, carry_out·10 + digit_sum equals opnd_a + opnd_b + carry_in.
- R4: With dec_mode = 1 and both digits in 0..9, digit_sum is always in the range 0..9.
- R5: With dec_mode = 1 and both digits in 0..9, carry_out is 1 exactly when opnd_a + opnd_b + carry_in exceeds 9, and in that case digit_sum is the raw low nibble plus 0110 modulo 16.
- R6: In decimal mode, 6 + 7 with carry_in 0 gives carry_out 1 and digit_sum 0011.
- R7: In decimal mode, 9 + 9 with carry_in 1 gives carry_out 1 and digit_sum 1001.
- R8: Two instances chained through carry_out to carry_in add two-digit decimal numbers 00..99 correctly, including the final carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 4 | First operand digit |
| opnd_b | input | 4 | Second operand digit |
| carry_in | input | 1 | Carry from the lower digit |
| dec_mode | input | 1 | 1 selects decimal correction, 0 selects plain binary |
| digit_sum | output | 4 | Result digit |
| carry_out | output | 1 | Carry to the next digit |

## Verification
The block holds no state, so a faulty carry term or a wrong overflow test appears at the outputs in the same cycle as the operands that expose it. A fault in the lookahead logic affects both modes, while a wrong correction constant or overflow condition affects only decimal results above nine. For that reason the bench sweeps every legal decimal case and every binary case. A fault in the carry-out path may pass single-digit checks that look only at the sum nibble, but the chained two-digit sums catch it in their upper digit.

// File: rtl/bcd_add_pkg.sv
package bcd_add_pkg;
   typedef enum logic {
      MODE_BIN = 1'b0,
      MODE_DEC = 1'b1
   } add_mode_e;

   localparam int DEC_RADIX   = 10;
   localparam int FIX_BY_ADD  = 0;
   localparam int FIX_BY_SUB  = 1;
endpackage

// File: rtl/bcd_cla.sv
module bcd_cla #(
   parameter int W = 4
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         ci,
   output logic [W-1:0] s,
   output logic         co
);
   logic [W-1:0] prop, gen, half;
   logic [W:0]   cy;

   assign prop = a | b;
   assign gen  = a & b;
   assign half = a ^ b;

   // every carry is a flat sum of products over gen/prop/ci
   always_comb begin
      logic acc;
      logic chain;
      cy = '0;
      cy[0] = ci;
      for (int i = 0; i < W; i++) begin
         acc = 1'b0;
         for (int j = 0; j <= i; j++) begin
            chain = gen[j];
            for (int k = j + 1; k <= i; k++) chain = chain & prop[k];
            acc = acc | chain;
         end
         chain = ci;
         for (int k = 0; k <= i; k++) chain = chain & prop[k];
         cy[i+1] = acc | chain;
      end
   end

   assign s  = half ^ cy[W-1:0];
   assign co = cy[W];

   always_comb begin
      AST_CLA_RAW_SUM: assert ({co, s} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci})); // R1
   end
endmodule

// File: rtl/bcd_fix.sv
module bcd_fix
   import bcd_add_pkg::*;
#(
   parameter int W          = 4,
   parameter int CORR_STYLE = FIX_BY_ADD
) (
   input  logic [W:0]   raw,
   output logic         ovf,
   output logic [W-1:0] fixed
);
   localparam logic [W-1:0] ADJ = W'((1 << W) - DEC_RADIX);
   localparam logic [W-1:0] TEN = W'(DEC_RADIX);
   localparam logic [W:0]   MAXLEGAL = (W+1)'(2 * DEC_RADIX - 1);

   assign ovf = raw[W] | (raw[W-1] & (raw[W-2] | raw[W-3]));

   generate
      if (CORR_STYLE == FIX_BY_ADD) begin : g_add
         assign fixed = raw[W-1:0] + ADJ;
      end else begin : g_sub
         assign fixed = raw[W-1:0] - TEN;
      end
   endgenerate

   always_comb begin
      if (raw <= MAXLEGAL) begin
         AST_FIX_DETECT: assert (ovf == (raw > (W+1)'(DEC_RADIX - 1))); // R5
         if (ovf) begin
            AST_FIX_RANGE: assert (fixed < TEN); // R4
         end
      end
   end
endmodule

// File: rtl/bcd_digit_adder.sv
module bcd_digit_adder
   import bcd_add_pkg::*;
#(
   parameter int DIGIT_W    = 4,
   parameter int CORR_STYLE = FIX_BY_ADD
) (
   input  logic [3:0] opnd_a,
   input  logic [3:0] opnd_b,
   input  logic       carry_in,
   input  logic       dec_mode,
   output logic [3:0] digit_sum,
   output logic       carry_out
);
   localparam logic [DIGIT_W-1:0] DMAX = DIGIT_W'(DEC_RADIX - 1);

   generate
      if (DIGIT_W != 4) begin : g_bad_width
         $error("bcd_digit_adder: DIGIT_W must be 4");
      end
      if (CORR_STYLE != FIX_BY_ADD && CORR_STYLE != FIX_BY_SUB) begin : g_bad_style
         $error("bcd_digit_adder: unknown CORR_STYLE");
      end
   endgenerate

   logic [DIGIT_W-1:0] raw_lo, fix_lo;
   logic               raw_co, dec_ovf;
   add_mode_e          mode;

   assign mode = add_mode_e'(dec_mode);

   bcd_cla #(.W(DIGIT_W)) u_cla (
      .a  (opnd_a),
      .b  (opnd_b),
      .ci (carry_in),
      .s  (raw_lo),
      .co (raw_co)
   );

   bcd_fix #(.W(DIGIT_W), .CORR_STYLE(CORR_STYLE)) u_fix (
      .raw   ({raw_co, raw_lo}),
      .ovf   (dec_ovf),
      .fixed (fix_lo)
   );

   always_comb begin
      if (mode == MODE_DEC) begin
         carry_out = dec_ovf;
         digit_sum = dec_ovf ? fix_lo : raw_lo;
      end else begin
         carry_out = raw_co;
         digit_sum = raw_lo;
      end
   end

   always_comb begin
      if (mode == MODE_BIN) begin
         AST_BIN_PASSTHRU: assert ({carry_out, digit_sum} ==
            ({1'b0, opnd_a} + {1'b0, opnd_b} + {4'b0, carry_in})); // R2
      end
      if (mode == MODE_DEC && opnd_a <= DMAX && opnd_b <= DMAX) begin
         AST_DEC_VALUE: assert ((carry_out ? 5'd10 : 5'd0) + {1'b0, digit_sum} ==
            ({1'b0, opnd_a} + {1'b0, opnd_b} + {4'b0, carry_in})); // R3
         AST_DEC_DIGIT: assert (digit_sum <= DMAX); // R4
      end
   end
endmodule

// File: tb/bcd_digit_adder_test.sv
module bcd_digit_adder_test;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic [3:0] a_lo, b_lo, a_hi, b_hi, s_lo, s_hi;
   logic       cin, mode, c_mid, c_top, cin_hi, mode_hi;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   bcd_digit_adder uut (
      .opnd_a(a_lo), .opnd_b(b_lo), .carry_in(cin), .dec_mode(mode),
      .digit_sum(s_lo), .carry_out(c_mid)
   );

   bcd_digit_adder uut_hi (
      .opnd_a(a_hi), .opnd_b(b_hi), .carry_in(cin_hi), .dec_mode(mode_hi),
      .digit_sum(s_hi), .carry_out(c_top)
   );

   assign cin_hi  = c_mid;
   assign mode_hi = mode;

   task automatic check(string req, int got, int exp);
      n_checks++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   // reference: returns {carry, digit} packed as carry*16 + digit
   function automatic int ref_model(int a, int b, int c, int dec);
      int t;
      t = a + b + c;
      if (dec != 0) begin
         if (t > 9) return 16 + (t - 10);
         return t;
      end
      return t;
   endfunction

   task automatic drive_lo(int a, int b, int c, int dec);
      @(posedge clk);
      #2;
      a_lo = 4'(a); b_lo = 4'(b); cin = c[0]; mode = dec[0];
      @(negedge clk);
   endtask

   initial begin
      a_lo = 0; b_lo = 0; cin = 0; mode = 0; a_hi = 0; b_hi = 0;
      @(negedge clk);
      check("R2 idle zero", {27'd0, c_mid, s_lo}, 0);

      // R6 named case
      drive_lo(6, 7, 0, 1);
      check("R6 carry", int'(c_mid), 1);
      check("R6 digit", int'(s_lo), 3);
      // R7 largest legal case
      drive_lo(9, 9, 1, 1);
      check("R7 carry", int'(c_mid), 1);
      check("R7 digit", int'(s_lo), 9);
      // R5 boundary at exactly nine and ten
      drive_lo(4, 5, 0, 1);
      check("R5 nine no carry", int'(c_mid), 0);
      drive_lo(4, 5, 1, 1);
      check("R5 ten carry", int'(c_mid), 1);
      check("R5 ten digit", int'(s_lo), 0);

      // R3 R4 R5: full decimal sweep
      for (int c = 0; c < 2; c++)
         for (int a = 0; a < 10; a++)
            for (int b = 0; b < 10; b++) begin
               int e;
               drive_lo(a, b, c, 1);
               e = ref_model(a, b, c, 1);
               check("R3 decimal sum", {27'd0, c_mid, s_lo}, e);
               if (s_lo > 9) check("R4 digit range", int'(s_lo), 9);
            end

      // R1 R2: full binary sweep
      for (int c = 0; c < 2; c++)
         for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++) begin
               drive_lo(a, b, c, 0);
               check("R1 R2 binary sum", {27'd0, c_mid, s_lo}, ref_model(a, b, c, 0));
            end

      // R8: chained two-digit decimal addition
      for (int x = 0; x < 100; x += 9)
         for (int y = 0; y < 100; y += 11)
            for (int c = 0; c < 2; c++) begin
               int tot;
               @(posedge clk);
               #2;
               mode = 1;
               a_lo = 4'(x % 10); a_hi = 4'(x / 10);
               b_lo = 4'(y % 10); b_hi = 4'(y / 10);
               cin = c[0];
               @(negedge clk);
               tot = x + y + c;
               check("R8 chained", int'(c_top) * 100 + int'(s_hi) * 10 + int'(s_lo), tot);
            end
      @(posedge clk);
      #2;
      mode = 1; a_lo = 9; b_lo = 9; a_hi = 9; b_hi = 9; cin = 1;
      @(negedge clk);
      check("R8 chained max", int'(c_top) * 100 + int'(s_hi) * 10 + int'(s_lo), 199);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule